// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block brings DDR2 or low-power DDR devices out of power-up. It issues a fixed series of direct commands to one or two ranks. A one-cycle start pulse launches the series. Each command goes out as one packed 32-bit word over a valid/ready handshake toward the controller's command port. A programmable idle gap separates each accepted command from the next one. At the end of the series the block raises a flag that enables periodic refresh, together with a completion flag.

An input selects the profile. The DDR2 profile runs a twelve-command pass per rank. That pass includes the DLL reset and the OCD calibration entry and exit. The low-power profile runs a shorter pass per rank, with an optional extended mode write. Rank 0 is always finished before rank 1 starts. A second input decides whether rank 1 is visited at all. The profile, the rank count, the optional write and the gap length are all captured when the start pulse is taken.

Top module: `dram_init_seq`

## Requirements
- R1: The command word carries the command kind in bits [27:24], where 0 is a mode-register write, 1 is precharge-all, 5 is auto-refresh and 7 is deselect. Bit 20 selects the rank (0 or 1). Bits [18:16] hold the mode-register bank (0 = MR, 1 = EMR1, 2 = EMR2, 3 = EMR3). Bits [15:0] hold the mode value. All other bits are zero.
- R2: With `lpProfile` low, each rank gets these twelve commands in this order:
  - deselect, then precharge-all;
  - EMR2 = 0x0000, then EMR3 = 0x0000;
  - EMR1 = 0x0400, then MR = 0x0542;
  - precharge-all, then two auto-refresh commands;
  - MR = 0x0442, EMR1 = 0x0780, then EMR1 = 0x0400.
- R3: With `lpProfile` high, each rank gets deselect, precharge-all, two auto-refresh commands and MR = 0x0032. If `lpEmrsEn` is high, EMR2 = 0x0020 follows as a sixth command.
- R4: Every rank-0 command is accepted before any rank-1 command is presented. When `twoRank` is low, no rank-1 command is issued.
- R5: While `cmdValid` is high and `cmdReady` is low, `cmdWord` holds its value. Each handshake advances the series by exactly one command.
- R6: After a handshake that is not the last one, `cmdValid` stays low for exactly `gapCycles` cycles before the next command. The first command is valid in the cycle after the start pulse is sampled.
- R7: `refreshEn` and `initDone` stay low for the whole series. Both rise in the cycle after the final handshake. No command is presented while they are high.
- R8: A start pulse that arrives while a series is running is ignored. The configuration inputs are captured only when a start pulse is accepted.
- R9: A start pulse that arrives after completion clears both flags and runs the series again from its first command.
- R10: A synchronous reset returns the block to idle, with `cmdValid`, `refreshEn` and `initDone` low, and it aborts any series in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | Launches the power-up series |
| twoRank | input | 1 | Also initialize rank 1 |
| lpProfile | input | 1 | 1 selects the low-power DDR series, 0 selects DDR2 |
| lpEmrsEn | input | 1 | Adds the EMR2 write to the low-power series |
| gapCycles | input | GAP_W | Idle cycles after each accepted command |
| cmdReady | input | 1 | Command port accepts the word |
| cmdValid | output | 1 | A command word is presented |
| cmdWord | output | 32 | Packed command |
| refreshEn | output | 1 | Auto-refresh may run |
| initDone | output | 1 | Series complete |

## Verification
The sequence is driven under six configurations. Together they cover both profiles, both rank counts, the low-power series with and without its extra EMR2 write, gaps of zero to five cycles, and port back-pressure of zero to two cycles.

The zero-gap runs show that back-to-back commands do not skip steps. The stalled runs show that the word holds while it waits. The two-rank runs show that the rank bit switches only after a full pass on rank 0.

In one DDR2 run a second start pulse arrives mid-series with the profile and rank inputs changed. That run shows the configuration is captured once at start. Directed tests cover the reset state, a reset in mid-series, and a restart after completion.

// File: rtl/dis_pkg.sv
`timescale 1ns/1ps
package dis_pkg;

  localparam int WORD_W   = 32;
  localparam int KIND_LSB = 24;
  localparam int RANK_BIT = 20;
  localparam int BANK_LSB = 16;
  localparam int VAL_W    = 16;

  // number of commands per rank pass
  localparam int DDR2_PASS = 12;
  localparam int LP_PASS   = 5;   // plus one with the optional EMR2 write
  localparam int STEP_W    = $clog2(DDR2_PASS);

  // mode values
  localparam logic [VAL_W-1:0] MV_DLL_ON     = 16'h0400;
  localparam logic [VAL_W-1:0] MV_DLL_RESET  = 16'h0542;
  localparam logic [VAL_W-1:0] MV_DLL_RUN    = 16'h0442;
  localparam logic [VAL_W-1:0] MV_OCD_DFLT   = 16'h0780;
  localparam logic [VAL_W-1:0] MV_LP_MODE    = 16'h0032;
  localparam logic [VAL_W-1:0] MV_LP_EXT     = 16'h0020;

  typedef enum logic [3:0] {
    CMD_MRW  = 4'd0,
    CMD_PALL = 4'd1,
    CMD_AREF = 4'd5,
    CMD_DSEL = 4'd7
  } cmdKind_t;

  typedef struct packed {
    cmdKind_t         kind;
    logic [2:0]       bank;
    logic [VAL_W-1:0] value;
  } stepEntry_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCfg;
    logic advance;
    logic loadGap;
    logic tickGap;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_GAP,
    ST_DONE
  } seqState_t;

  function automatic stepEntry_t mkEntry(cmdKind_t k, logic [2:0] b, logic [VAL_W-1:0] v);
    stepEntry_t e;
    e.kind  = k;
    e.bank  = b;
    e.value = v;
    return e;
  endfunction

  function automatic stepEntry_t ddr2Entry(logic [STEP_W-1:0] idx);
    case (idx)
      4'd0:    return mkEntry(CMD_DSEL, 3'd0, '0);
      4'd1:    return mkEntry(CMD_PALL, 3'd0, '0);
      4'd2:    return mkEntry(CMD_MRW,  3'd2, '0);
      4'd3:    return mkEntry(CMD_MRW,  3'd3, '0);
      4'd4:    return mkEntry(CMD_MRW,  3'd1, MV_DLL_ON);
      4'd5:    return mkEntry(CMD_MRW,  3'd0, MV_DLL_RESET);
      4'd6:    return mkEntry(CMD_PALL, 3'd0, '0);
      4'd7:    return mkEntry(CMD_AREF, 3'd0, '0);
      4'd8:    return mkEntry(CMD_AREF, 3'd0, '0);
      4'd9:    return mkEntry(CMD_MRW,  3'd0, MV_DLL_RUN);
      4'd10:   return mkEntry(CMD_MRW,  3'd1, MV_OCD_DFLT);
      default: return mkEntry(CMD_MRW,  3'd1, MV_DLL_ON);
    endcase
  endfunction

  function automatic stepEntry_t lpEntry(logic [STEP_W-1:0] idx);
    case (idx)
      4'd0:    return mkEntry(CMD_DSEL, 3'd0, '0);
      4'd1:    return mkEntry(CMD_PALL, 3'd0, '0);
      4'd2:    return mkEntry(CMD_AREF, 3'd0, '0);
      4'd3:    return mkEntry(CMD_AREF, 3'd0, '0);
      4'd4:    return mkEntry(CMD_MRW,  3'd0, MV_LP_MODE);
      default: return mkEntry(CMD_MRW,  3'd2, MV_LP_EXT);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] packWord(stepEntry_t e, logic rank);
    logic [WORD_W-1:0] w;
    w                   = '0;
    w[KIND_LSB +: 4]    = e.kind;
    w[RANK_BIT]         = rank;
    w[BANK_LSB +: 3]    = e.bank;
    w[VAL_W-1:0]        = e.value;
    return w;
  endfunction

endpackage

// File: rtl/dis_datapath.sv
`timescale 1ns/1ps
module dis_datapath
  import dis_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic              twoRank,
  input  logic              lpProfile,
  input  logic              lpEmrsEn,
  input  logic [GAP_W-1:0]  gapCycles,
  output logic [WORD_W-1:0] cmdWord,
  output logic              lastStep,
  output logic              lastRank,
  output logic              gapIsZero,
  output logic              gapExpire
);

  localparam logic [STEP_W-1:0] DDR2_LAST  = STEP_W'(DDR2_PASS - 1);
  localparam logic [STEP_W-1:0] LP_LAST    = STEP_W'(LP_PASS - 1);
  localparam logic [STEP_W-1:0] LP_LAST_EX = STEP_W'(LP_PASS);

  logic              cfgTwoRank;
  logic              cfgLp;
  logic              cfgLpEmrs;
  logic [GAP_W-1:0]  cfgGap;
  logic [STEP_W-1:0] stepIdx;
  logic              rankIdx;
  logic [GAP_W-1:0]  gapCnt;
  logic [STEP_W-1:0] passLast;
  stepEntry_t        curEntry;

  // configuration captured at start
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgTwoRank <= 1'b0;
      cfgLp      <= 1'b0;
      cfgLpEmrs  <= 1'b0;
      cfgGap     <= '0;
    end else if (strobe.loadCfg) begin
      cfgTwoRank <= twoRank;
      cfgLp      <= lpProfile;
      cfgLpEmrs  <= lpEmrsEn;
      cfgGap     <= gapCycles;
    end
  end

  always_comb begin
    if (cfgLp) passLast = cfgLpEmrs ? LP_LAST_EX : LP_LAST;
    else       passLast = DDR2_LAST;
  end

  assign lastStep = (stepIdx == passLast);
  assign lastRank = rankIdx | ~cfgTwoRank;

  // step and rank position
  always_ff @(posedge clk) begin
    if (rst || strobe.loadCfg) begin
      stepIdx <= '0;
      rankIdx <= 1'b0;
    end else if (strobe.advance) begin
      if (lastStep) begin
        stepIdx <= '0;
        rankIdx <= 1'b1;
      end else begin
        stepIdx <= stepIdx + 1'b1;
      end
    end
  end

  // inter-command gap counter
  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt <= '0;
    end else if (strobe.loadGap) begin
      gapCnt <= cfgGap;
    end else if (strobe.tickGap && gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign gapIsZero = (cfgGap == '0);
  assign gapExpire = (gapCnt <= GAP_W'(1));

  assign curEntry = cfgLp ? lpEntry(stepIdx) : ddr2Entry(stepIdx);
  assign cmdWord  = packWord(curEntry, rankIdx);

endmodule

// File: rtl/dis_ctrl.sv
`timescale 1ns/1ps
module dis_ctrl
  import dis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startPulse,
  input  logic       cmdReady,
  input  logic       lastStep,
  input  logic       lastRank,
  input  logic       gapIsZero,
  input  logic       gapExpire,
  output seqStrobe_t strobe,
  output logic       cmdValid,
  output logic       doneFlag
);

  seqState_t state;
  seqState_t stateNxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (startPulse) begin
          strobe.loadCfg = 1'b1;
          stateNxt       = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (cmdReady) begin
          if (lastStep && lastRank) begin
            stateNxt = ST_DONE;
          end else begin
            strobe.advance = 1'b1;
            if (gapIsZero) begin
              stateNxt = ST_ISSUE;
            end else begin
              strobe.loadGap = 1'b1;
              stateNxt       = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        strobe.tickGap = 1'b1;
        if (gapExpire) stateNxt = ST_ISSUE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign cmdValid = (state == ST_ISSUE);
  assign doneFlag = (state == ST_DONE);

endmodule

// File: rtl/dram_init_seq.sv
`timescale 1ns/1ps
module dram_init_seq
  import dis_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startPulse,
  input  logic              twoRank,
  input  logic              lpProfile,
  input  logic              lpEmrsEn,
  input  logic [GAP_W-1:0]  gapCycles,
  input  logic              cmdReady,
  output logic              cmdValid,
  output logic [WORD_W-1:0] cmdWord,
  output logic              refreshEn,
  output logic              initDone
);

  seqStrobe_t strobe;
  logic       lastStep;
  logic       lastRank;
  logic       gapIsZero;
  logic       gapExpire;
  logic       doneFlag;

  dis_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .cmdReady   (cmdReady),
    .lastStep   (lastStep),
    .lastRank   (lastRank),
    .gapIsZero  (gapIsZero),
    .gapExpire  (gapExpire),
    .strobe     (strobe),
    .cmdValid   (cmdValid),
    .doneFlag   (doneFlag)
  );

  dis_datapath #(.GAP_W(GAP_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .twoRank    (twoRank),
    .lpProfile  (lpProfile),
    .lpEmrsEn   (lpEmrsEn),
    .gapCycles  (gapCycles),
    .cmdWord    (cmdWord),
    .lastStep   (lastStep),
    .lastRank   (lastRank),
    .gapIsZero  (gapIsZero),
    .gapExpire  (gapExpire)
  );

  assign refreshEn = doneFlag;
  assign initDone  = doneFlag;

endmodule

// File: rtl/dis_chk.sv
`timescale 1ns/1ps
module dis_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [31:0] cmdWord,
  input logic        refreshEn,
  input logic        initDone
);

  // R1
  legal_kind_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> (cmdWord[27:24] == 4'd0 || cmdWord[27:24] == 4'd1 ||
                  cmdWord[27:24] == 4'd5 || cmdWord[27:24] == 4'd7));

  // R5
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdWord)));

  // R7
  done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(initDone) |-> $past(cmdValid && cmdReady));

  // R7
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    refreshEn |-> !cmdValid);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!cmdValid && !initDone && !refreshEn));

endmodule

bind dram_init_seq dis_chk u_dis_chk (
  .clk       (clk),
  .rst       (rst),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .cmdWord   (cmdWord),
  .refreshEn (refreshEn),
  .initDone  (initDone)
);

// File: tb/test_dram_init_seq.sv
`timescale 1ns/1ps
module test_dram_init_seq;

  localparam int GAP_W = 8;
  localparam int N_CASES = 6;
  // {lp, lpEmrs, twoRank, midStart, gap[7:0], readyLag[3:0]}
  localparam logic [15:0] CASES [N_CASES] = '{
    {4'b0010, 8'd3, 4'd0},
    {4'b0000, 8'd0, 4'd2},
    {4'b1110, 8'd1, 4'd1},
    {4'b1010, 8'd5, 4'd0},
    {4'b1100, 8'd0, 4'd0},
    {4'b0011, 8'd2, 4'd1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             startPulse = 1'b0;
  logic             twoRank = 1'b0;
  logic             lpProfile = 1'b0;
  logic             lpEmrsEn = 1'b0;
  logic [GAP_W-1:0] gapCycles = '0;
  logic             cmdReady = 1'b0;
  logic             cmdValid;
  logic [31:0]      cmdWord;
  logic             refreshEn;
  logic             initDone;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dram_init_seq #(.GAP_W(GAP_W)) i_dram_init_seq (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .twoRank    (twoRank),
    .lpProfile  (lpProfile),
    .lpEmrsEn   (lpEmrsEn),
    .gapCycles  (gapCycles),
    .cmdReady   (cmdReady),
    .cmdValid   (cmdValid),
    .cmdWord    (cmdWord),
    .refreshEn  (refreshEn),
    .initDone   (initDone)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected word from the requirement text
  function automatic logic [31:0] expWord(bit lp, bit rank, int step);
    logic [3:0]  k = 4'd0;
    logic [2:0]  b = 3'd0;
    logic [15:0] v = 16'h0;
    if (!lp) begin
      case (step)
        0: k = 4'd7;
        1: k = 4'd1;
        2: b = 3'd2;
        3: b = 3'd3;
        4: begin b = 3'd1; v = 16'h0400; end
        5: v = 16'h0542;
        6: k = 4'd1;
        7: k = 4'd5;
        8: k = 4'd5;
        9: v = 16'h0442;
        10: begin b = 3'd1; v = 16'h0780; end
        default: begin b = 3'd1; v = 16'h0400; end
      endcase
    end else begin
      case (step)
        0: k = 4'd7;
        1: k = 4'd1;
        2: k = 4'd5;
        3: k = 4'd5;
        4: v = 16'h0032;
        default: begin b = 3'd2; v = 16'h0020; end
      endcase
    end
    return {4'h0, k, 3'b000, rank, 1'b0, b, v};
  endfunction

  task automatic runCase(input bit lp, input bit emrs, input bit two, input bit mid,
                         input int gap, input int lag);
    int  perRank = lp ? (emrs ? 6 : 5) : 12;
    int  total   = perRank * (two ? 2 : 1);
    int  idx     = 0;
    int  idle    = 0;
    int  held    = 0;
    int  cyc     = 0;
    int  sinceHs = 0;
    bit  midDone = 0;
    bit  refLow  = 1;
    logic [31:0] prevWord = '0;
    logic [31:0] want;
    @(negedge clk);
    lpProfile  = lp;
    lpEmrsEn   = emrs;
    twoRank    = two;
    gapCycles  = GAP_W'(gap);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    // R9: flags cleared by the start, first command ready (R6)
    check(!refreshEn && !initDone, "R9 flags clear on start", {30'd0, refreshEn, initDone}, 32'd0);
    check(cmdValid, "R6 first command right after start", {31'd0, cmdValid}, 32'd1);
    while (!initDone && cyc < 3000) begin
      startPulse = 1'b0;
      if (refreshEn) refLow = 0;
      if (cmdValid) begin
        if (held == 0) begin
          want = (idx < total) ? expWord(lp, (idx >= perRank), idx % perRank) : 32'hDEAD_BEEF;
          check(cmdWord == want, lp ? "R3/R4/R1 low-power word" : "R2/R4/R1 DDR2 word", cmdWord, want);
          if (idx > 0) check(idle == gap, "R6 gap length", 32'(idle), 32'(gap));
        end else begin
          check(cmdWord == prevWord, "R5 word held while stalled", cmdWord, prevWord);
        end
        prevWord = cmdWord;
        if (held >= lag) begin
          cmdReady = 1'b1;
          idx++;
          held    = 0;
          idle    = 0;
          sinceHs = 0;
        end else begin
          cmdReady = 1'b0;
          held++;
        end
      end else begin
        cmdReady = 1'b0;
        idle++;
      end
      // R8: a start pulse while busy with different configuration
      if (mid && !midDone && idx == 3 && held == 0) begin
        startPulse = 1'b1;
        lpProfile  = ~lp;
        twoRank    = ~two;
        midDone    = 1;
      end
      @(negedge clk);
      cyc++;
      sinceHs++;
    end
    cmdReady   = 1'b0;
    startPulse = 1'b0;
    check(idx == total, mid ? "R8 count unchanged by busy start" : "R4/R5 command count", 32'(idx), 32'(total));
    check(refreshEn && initDone, "R7 flags raised at end", {30'd0, refreshEn, initDone}, 32'd3);
    check(sinceHs == 1, "R7 flags one cycle after last accept", 32'(sinceHs), 32'd1);
    check(refLow, "R7 refresh low during series", {31'd0, refLow}, 32'd1);
    repeat (3) @(negedge clk);
    check(initDone && !cmdValid, "R7 stays done, no commands", {30'd0, initDone, cmdValid}, 32'd2);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!cmdValid && !initDone && !refreshEn, "R10 reset state",
          {29'd0, cmdValid, initDone, refreshEn}, 32'd0);

    for (int i = 0; i < N_CASES; i++) begin
      c = CASES[i];
      runCase(c[15], c[14], c[13], c[12], int'(c[11:4]), int'(c[3:0]));
    end

    // R10 reset in mid-series
    @(negedge clk);
    lpProfile  = 1'b0;
    twoRank    = 1'b1;
    gapCycles  = 8'd1;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    cmdReady   = 1'b1;
    repeat (4) @(negedge clk);
    cmdReady = 1'b0;
    rst      = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!cmdValid && !initDone && !refreshEn, "R10 reset aborts series",
          {29'd0, cmdValid, initDone, refreshEn}, 32'd0);
    repeat (2) @(negedge clk);
    check(!cmdValid, "R10 stays idle without start", {31'd0, cmdValid}, 32'd0);
    // after reset a new series starts from the first command
    runCase(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule